// File: doc/BRIEF.md
# PCIe Function Power State Controller

This block tracks the PCI power-management state of a single network function. The four states are uninitialized D0, active D0, D3hot, and a reset state that the function sits in while the fundamental reset pin is held low; D3cold is treated as part of that reset state. Configuration software moves the function between states through strobed field writes. Typical writes are a target value for the power-state field and an update of the command-register enables.

The block also owns the wake bits, PME enable and PME status. Whether fundamental reset clears them depends on whether the function advertises wake from D3cold. That capability needs both an auxiliary-power-present strap and an EEPROM bit that enables advanced D3cold wake. Otherwise the wake bits are only cleared by power-on reset.

From the PME enable bit, the device-control aux-power enable and an EEPROM aux-regime bit, the block derives a 2-bit budget code. Board power logic uses that code to know how much auxiliary current the function may draw while in reset.

Top module: `pcie_fn_pwr_ctrl`

## Requirements
- R1: While `por_n` is low at a clock edge, the state becomes uninitialized D0 (`pwr_state` = 2'b00), and `pme_en` and `pme_status` become 0. This holds for every strap setting.
- R2: `fund_rst_n` low at a clock edge makes the state 2'b11 (reset) from any state. The first edge with `fund_rst_n` high while in reset returns the state to 2'b00.
- R3: In state 2'b00, an edge with `cmd_mem_en` or `cmd_bm_en` high moves the state to active D0 (2'b01).
- R4: A power-state write of 2'b11 in state 2'b01 moves to D3hot (2'b10). A write of 2'b00 in state 2'b10 moves to 2'b00. Any other value, or a write in another state, leaves the state unchanged.
- R5: `d3cold_wake_cap` is 1 exactly when `strap_aux_present` and `ee_adv_d3wake` are both 1.
- R6: When `d3cold_wake_cap` is 1, fundamental reset leaves `pme_en` and `pme_status` unchanged. When it is 0, fundamental reset clears both bits.
- R7: `wake_evt` sets `pme_status` only when `pme_en` is 1. A status write with data 1 clears it, and a status write with data 0 has no effect. If a wake event and a clearing write arrive on the same edge, the status stays set.
- R8: `pme_assert` is 1 exactly when `pme_en` and `pme_status` are both 1.
- R9: `aux_budget` is 2'b00 when `ee_aux_regime` is 0. When `ee_aux_regime` is 1, the code is 2'b10 if `devctl_aux_pm_en` is 1, else 2'b01 if `pme_en` is 1, else 2'b00. The code follows its inputs in the same cycle.
- R10: Configuration writes, including power-state, PME enable and PME status writes, are ignored while `fund_rst_n` is low or the state is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| fund_rst_n | input | 1 | Fundamental reset pin, active low |
| cfg_pst_wr | input | 1 | Strobe: write to the power-state field |
| cfg_pst_val | input | 2 | Power-state value written |
| cfg_pme_en_wr | input | 1 | Strobe: write to the PME enable bit |
| cfg_pme_en_val | input | 1 | PME enable value written |
| cfg_pme_sts_wr | input | 1 | Strobe: write to the PME status bit |
| cfg_pme_sts_val | input | 1 | PME status write data (1 clears) |
| cmd_mem_en | input | 1 | Memory-space enable from the command register |
| cmd_bm_en | input | 1 | Bus-master enable from the command register |
| devctl_aux_pm_en | input | 1 | Aux power PM enable from device control |
| strap_aux_present | input | 1 | Strap: auxiliary power is present |
| ee_adv_d3wake | input | 1 | EEPROM: advanced D3cold wake enable |
| ee_aux_regime | input | 1 | EEPROM: comply with the aux power regime |
| wake_evt | input | 1 | Wake event pulse |
| pwr_state | output | 2 | 00 D0 uninit, 01 D0 active, 10 D3hot, 11 reset |
| d3cold_wake_cap | output | 1 | D3cold wake capability advertised |
| pme_en | output | 1 | PME enable bit |
| pme_status | output | 1 | PME status bit |
| pme_assert | output | 1 | PME request to the link layer |
| aux_budget | output | 2 | Aux power budget code |

## Verification
Several rules are checked on every cycle: entry into the reset state on a low fundamental reset, D3hot being reachable only from active D0, and the survival or clearing of the wake bits across fundamental reset according to the advertised capability. The same per-cycle checks cover status rising only under an enabled PME, the PME request tracking both bits, and the minimum budget outside the aux regime. The bench scenarios are needed for the orderings that only show over a sequence. These include ignored power-state values in the wrong state, a clearing write racing a wake event, configuration writes dropped during reset, and the full budget priority.

// File: rtl/pcie_pwr_pkg.sv
// Shared types and encodings for the function power-state controller.
// Assumes a 2-bit power-state field, as in the PM control/status register.
package pcie_pwr_pkg;
    localparam int PST_W = 2;
    localparam int BUD_W = 2;

    typedef enum logic [PST_W-1:0] {
        PS_D0U = 2'b00,
        PS_D0A = 2'b01,
        PS_D3H = 2'b10,
        PS_DR  = 2'b11
    } pwr_state_e;

    localparam logic [PST_W-1:0] PMCSR_D0 = 2'b00;
    localparam logic [PST_W-1:0] PMCSR_D3 = 2'b11;

    localparam logic [BUD_W-1:0] BUD_MIN  = 2'b00;
    localparam logic [BUD_W-1:0] BUD_WAKE = 2'b01;
    localparam logic [BUD_W-1:0] BUD_FULL = 2'b10;
endpackage

// File: rtl/pwr_state_fsm.sv
// Power-state sequencer for one function.
// Does: holds the D0u/D0a/D3hot/reset state and applies configuration moves.
// Assumes: rst_n is the synchronous power-on reset, and cfg_ok is low whenever
// configuration writes must be dropped.
module pwr_state_fsm
    import pcie_pwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fund_rst_n,
    input  logic             cfg_ok,
    input  logic             pst_wr,
    input  logic [PST_W-1:0] pst_val,
    input  logic             mem_en,
    input  logic             bm_en,
    output pwr_state_e       state
);
    pwr_state_e nxt;
    logic       go_d3;
    logic       go_d0;

    // Qualify the power-state writes that are allowed to take effect.
    always_comb begin
        go_d3 = cfg_ok && pst_wr && (pst_val == PMCSR_D3);
        go_d0 = cfg_ok && pst_wr && (pst_val == PMCSR_D0);
    end

    // Next-state selection; fundamental reset overrides all moves.
    always_comb begin
        nxt = state;
        if (!fund_rst_n) begin
            nxt = PS_DR;
        end else begin
            unique case (state)
                PS_DR:  nxt = PS_D0U;
                PS_D0U: if (mem_en || bm_en) nxt = PS_D0A;
                PS_D0A: if (go_d3) nxt = PS_D3H;
                PS_D3H: if (go_d0) nxt = PS_D0U;
                default: nxt = PS_D0U;
            endcase
        end
    end

    // State register, cleared to D0u by power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_D0U;
        else        state <= nxt;
    end
endmodule

// File: rtl/pme_regs.sv
// PME enable and PME status bits with a strap-dependent reset domain.
// Does: holds both wake bits and clears them on fundamental reset only when
// keep_on_fund is low.
// Assumes: cfg_ok already blocks writes during reset; a wake event that races
// a clearing write wins.
module pme_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic fund_rst_n,
    input  logic keep_on_fund,
    input  logic cfg_ok,
    input  logic en_wr,
    input  logic en_val,
    input  logic sts_wr,
    input  logic sts_val,
    input  logic wake_evt,
    output logic pme_en,
    output logic pme_sts
);
    logic fund_clr;
    logic sts_clr;
    logic sts_set;

    // Decode clear and set conditions for the two bits.
    always_comb begin
        fund_clr = !fund_rst_n && !keep_on_fund;
        sts_clr  = cfg_ok && sts_wr && sts_val;
        sts_set  = wake_evt && pme_en;
    end

    // PME enable bit: configuration-writable outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                pme_en <= 1'b0;
        else if (fund_clr)         pme_en <= 1'b0;
        else if (cfg_ok && en_wr)  pme_en <= en_val;
    end

    // PME status bit: set by an enabled wake, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)        pme_sts <= 1'b0;
        else if (fund_clr) pme_sts <= 1'b0;
        else if (sts_set)  pme_sts <= 1'b1;
        else if (sts_clr)  pme_sts <= 1'b0;
    end
endmodule

// File: rtl/aux_budget_enc.sv
// Aux power budget encoder.
// Does: picks the budget code from the regime bit, the device-control aux
// enable and the PME enable bit.
// Assumes: purely combinational, so the code follows its inputs in the same cycle.
module aux_budget_enc
    import pcie_pwr_pkg::*;
(
    input  logic             regime,
    input  logic             aux_pm_en,
    input  logic             pme_en,
    output logic [BUD_W-1:0] budget
);
    // Priority pick: regime gate, then full aux, then wake-enabled.
    always_comb begin
        if (!regime)        budget = BUD_MIN;
        else if (aux_pm_en) budget = BUD_FULL;
        else if (pme_en)    budget = BUD_WAKE;
        else                budget = BUD_MIN;
    end
endmodule

// File: rtl/pcie_fn_pwr_ctrl.sv
// Top level of the function power-state controller.
// Does: joins the state sequencer, the PME bits and the budget encoder, and
// derives the D3cold wake capability from the strap and the EEPROM bit.
// Assumes: all inputs are synchronous to clk, and por_n is the house reset.
module pcie_fn_pwr_ctrl
    import pcie_pwr_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             fund_rst_n,
    input  logic             cfg_pst_wr,
    input  logic [PST_W-1:0] cfg_pst_val,
    input  logic             cfg_pme_en_wr,
    input  logic             cfg_pme_en_val,
    input  logic             cfg_pme_sts_wr,
    input  logic             cfg_pme_sts_val,
    input  logic             cmd_mem_en,
    input  logic             cmd_bm_en,
    input  logic             devctl_aux_pm_en,
    input  logic             strap_aux_present,
    input  logic             ee_adv_d3wake,
    input  logic             ee_aux_regime,
    input  logic             wake_evt,
    output logic [PST_W-1:0] pwr_state,
    output logic             d3cold_wake_cap,
    output logic             pme_en,
    output logic             pme_status,
    output logic             pme_assert,
    output logic [BUD_W-1:0] aux_budget
);
    pwr_state_e st;
    logic       cfg_ok;
    logic       en_q;
    logic       sts_q;

    // Capability and write qualification.
    always_comb begin
        d3cold_wake_cap = strap_aux_present && ee_adv_d3wake;
        cfg_ok          = fund_rst_n && (st != PS_DR);
    end

    pwr_state_fsm u_fsm (
        .clk        (clk),
        .rst_n      (por_n),
        .fund_rst_n (fund_rst_n),
        .cfg_ok     (cfg_ok),
        .pst_wr     (cfg_pst_wr),
        .pst_val    (cfg_pst_val),
        .mem_en     (cmd_mem_en),
        .bm_en      (cmd_bm_en),
        .state      (st)
    );

    pme_regs u_pme (
        .clk          (clk),
        .rst_n        (por_n),
        .fund_rst_n   (fund_rst_n),
        .keep_on_fund (d3cold_wake_cap),
        .cfg_ok       (cfg_ok),
        .en_wr        (cfg_pme_en_wr),
        .en_val       (cfg_pme_en_val),
        .sts_wr       (cfg_pme_sts_wr),
        .sts_val      (cfg_pme_sts_val),
        .wake_evt     (wake_evt),
        .pme_en       (en_q),
        .pme_sts      (sts_q)
    );

    aux_budget_enc u_bud (
        .regime    (ee_aux_regime),
        .aux_pm_en (devctl_aux_pm_en),
        .pme_en    (en_q),
        .budget    (aux_budget)
    );

    // Output mapping and PME request.
    always_comb begin
        pwr_state  = st;
        pme_en     = en_q;
        pme_status = sts_q;
        pme_assert = en_q && sts_q;
    end
endmodule

// File: rtl/pcie_fn_pwr_ctrl_chk.sv
// Checker for the function power-state controller, bound to the top module.
module pcie_fn_pwr_ctrl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       fund_rst_n,
    input logic       ee_aux_regime,
    input logic [1:0] pwr_state,
    input logic       d3cold_wake_cap,
    input logic       pme_en,
    input logic       pme_status,
    input logic       pme_assert,
    input logic [1:0] aux_budget
);
    // R2
    dr_on_fund_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        !fund_rst_n |=> pwr_state == 2'b11);

    // R4
    d3_from_d0a_chk: assert property (@(posedge clk) disable iff (!por_n)
        (pwr_state == 2'b10 && $past(pwr_state) != 2'b10) |-> $past(pwr_state) == 2'b01);

    // R6
    pme_kept_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!fund_rst_n && d3cold_wake_cap) |=> pme_en == $past(pme_en));

    // R6
    pme_cleared_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!fund_rst_n && !d3cold_wake_cap) |=> (!pme_en && !pme_status));

    // R7
    sts_needs_en_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pme_status) |-> $past(pme_en));

    // R8
    pme_req_chk: assert property (@(posedge clk) disable iff (!por_n)
        pme_assert |-> (pme_en && pme_status));

    // R9
    min_budget_chk: assert property (@(posedge clk) disable iff (!por_n)
        !ee_aux_regime |-> aux_budget == 2'b00);
endmodule

bind pcie_fn_pwr_ctrl pcie_fn_pwr_ctrl_chk u_chk (
    .clk             (clk),
    .por_n           (por_n),
    .fund_rst_n      (fund_rst_n),
    .ee_aux_regime   (ee_aux_regime),
    .pwr_state       (pwr_state),
    .d3cold_wake_cap (d3cold_wake_cap),
    .pme_en          (pme_en),
    .pme_status      (pme_status),
    .pme_assert      (pme_assert),
    .aux_budget      (aux_budget)
);

// File: tb/pcie_fn_pwr_ctrl_bench.sv
module pcie_fn_pwr_ctrl_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       por_n = 1'b0, fund_rst_n = 1'b1;
    logic       cfg_pst_wr = 0, cfg_pme_en_wr = 0, cfg_pme_en_val = 0;
    logic       cfg_pme_sts_wr = 0, cfg_pme_sts_val = 0;
    logic [1:0] cfg_pst_val = 2'b00;
    logic       cmd_mem_en = 0, cmd_bm_en = 0, devctl_aux_pm_en = 0;
    logic       strap_aux_present = 0, ee_adv_d3wake = 0, ee_aux_regime = 0;
    logic       wake_evt = 0;
    logic [1:0] pwr_state, aux_budget;
    logic       d3cold_wake_cap, pme_en, pme_status, pme_assert;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    pcie_fn_pwr_ctrl u_pcie_fn_pwr_ctrl (.*);

    // Behavioural reference: integer state, updated on every edge.
    int m_st = 0;
    bit m_en = 0, m_sts = 0;

    always @(posedge clk) begin
        bit cap, ok;
        cap = strap_aux_present & ee_adv_d3wake;
        ok  = fund_rst_n && (m_st != 3);
        if (!por_n) begin
            m_st <= 0; m_en <= 0; m_sts <= 0;
        end else begin
            if (!fund_rst_n) m_st <= 3;
            else if (m_st == 3) m_st <= 0;
            else if (m_st == 0 && (cmd_mem_en || cmd_bm_en)) m_st <= 1;
            else if (m_st == 1 && ok && cfg_pst_wr && cfg_pst_val == 3) m_st <= 2;
            else if (m_st == 2 && ok && cfg_pst_wr && cfg_pst_val == 0) m_st <= 0;
            if (!fund_rst_n && !cap) begin
                m_en <= 0; m_sts <= 0;
            end else begin
                if (ok && cfg_pme_en_wr) m_en <= cfg_pme_en_val;
                if (wake_evt && m_en) m_sts <= 1;
                else if (ok && cfg_pme_sts_wr && cfg_pme_sts_val) m_sts <= 0;
            end
        end
    end

    task automatic cmp(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, 1 ns after the edge.
    always @(posedge clk) begin
        int bud;
        #1;
        if (por_n && !done) begin
            bud = !ee_aux_regime ? 0 : devctl_aux_pm_en ? 2 : m_en ? 1 : 0;
            cmp("R2/R3/R4 state", pwr_state, m_st);
            cmp("R5 cap", d3cold_wake_cap, strap_aux_present & ee_adv_d3wake);
            cmp("R6/R7 pme_en", pme_en, m_en);
            cmp("R6/R7 pme_status", pme_status, m_sts);
            cmp("R8 pme_assert", pme_assert, m_en & m_sts);
            cmp("R9 budget", aux_budget, bud);
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(4);
        por_n = 1'b1; step(1);
        // R1: reset state
        cmp("R1 state after por", pwr_state, 0);
        cmp("R1 pme_en after por", pme_en, 0);
        cmp("R1 pme_assert after por", pme_assert, 0);

        // R4: D3 write in D0u ignored
        cfg_pst_wr = 1; cfg_pst_val = 2'b11; step(1); cfg_pst_wr = 0;
        cmp("R4 D3 write in D0u ignored", pwr_state, 0);
        // R3: memory enable activates
        cmd_mem_en = 1; step(1);
        cmp("R3 mem enable -> D0a", pwr_state, 1);
        cfg_pst_wr = 1; cfg_pst_val = 2'b01; step(1); cfg_pst_wr = 0;
        cmp("R4 value 01 ignored", pwr_state, 1);
        cfg_pst_wr = 1; cfg_pst_val = 2'b11; step(1); cfg_pst_wr = 0;
        cmp("R4 D0a -> D3hot", pwr_state, 2);
        cmd_mem_en = 0;
        cfg_pst_wr = 1; cfg_pst_val = 2'b11; step(1); cfg_pst_wr = 0;
        cmp("R4 D3 write in D3hot holds", pwr_state, 2);
        cfg_pst_wr = 1; cfg_pst_val = 2'b00; step(1); cfg_pst_wr = 0;
        cmp("R4 D3hot -> D0u", pwr_state, 0);
        cmd_bm_en = 1; step(1);
        cmp("R3 bus master -> D0a", pwr_state, 1);

        // R7: wake without enable
        wake_evt = 1; step(1); wake_evt = 0;
        cmp("R7 wake ignored when disabled", pme_status, 0);
        cfg_pme_en_wr = 1; cfg_pme_en_val = 1; step(1); cfg_pme_en_wr = 0;
        wake_evt = 1; step(1); wake_evt = 0;
        cmp("R7 enabled wake sets status", pme_status, 1);
        cmp("R8 pme asserted", pme_assert, 1);
        cfg_pme_sts_wr = 1; cfg_pme_sts_val = 0; step(1); cfg_pme_sts_wr = 0;
        cmp("R7 write 0 no effect", pme_status, 1);
        cfg_pme_sts_wr = 1; cfg_pme_sts_val = 1; wake_evt = 1; step(1);
        cfg_pme_sts_wr = 0; wake_evt = 0;
        cmp("R7 wake beats clear", pme_status, 1);
        cfg_pme_sts_wr = 1; cfg_pme_sts_val = 1; step(1); cfg_pme_sts_wr = 0;
        cmp("R7 write 1 clears", pme_status, 0);

        // R9: budget codes
        devctl_aux_pm_en = 1; step(1);
        cmp("R9 no regime -> min", aux_budget, 0);
        ee_aux_regime = 1; step(1);
        cmp("R9 aux enable -> full", aux_budget, 2);
        devctl_aux_pm_en = 0; step(1);
        cmp("R9 pme_en -> wake", aux_budget, 1);

        // R5: capability combinations
        strap_aux_present = 1; step(1);
        cmp("R5 strap only", d3cold_wake_cap, 0);
        strap_aux_present = 0; ee_adv_d3wake = 1; step(1);
        cmp("R5 eeprom only", d3cold_wake_cap, 0);
        strap_aux_present = 1; step(1);
        cmp("R5 both set", d3cold_wake_cap, 1);

        // R6 / R2 / R10: fundamental reset with capability
        wake_evt = 1; step(1); wake_evt = 0;
        fund_rst_n = 0; step(1);
        cmp("R2 fund reset -> Dr", pwr_state, 3);
        cfg_pme_en_wr = 1; cfg_pme_en_val = 0; step(1); cfg_pme_en_wr = 0;
        cmp("R10 write in Dr ignored", pme_en, 1);
        cmp("R6 status kept with cap", pme_status, 1);
        fund_rst_n = 1; cmd_bm_en = 0; step(1);
        cmp("R2 release -> D0u", pwr_state, 0);
        cmp("R6 enable kept with cap", pme_en, 1);

        // R6: without capability the bits clear
        strap_aux_present = 0; fund_rst_n = 0; step(2);
        cmp("R6 enable cleared without cap", pme_en, 0);
        cmp("R6 status cleared without cap", pme_status, 0);
        fund_rst_n = 1; step(2);

        // R1: power-on reset clears even with capability
        strap_aux_present = 1;
        cfg_pme_en_wr = 1; cfg_pme_en_val = 1; step(1); cfg_pme_en_wr = 0;
        por_n = 0; step(1); por_n = 1; step(1);
        cmp("R1 por clears with cap", pme_en, 0);
        step(2);
        finish_run();
    end
endmodule